// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

The controller gathers 64 interrupt request lines into two banks of 32 bits and produces one combined interrupt signal for a single processor. Each bit of each bank is fixed at build time as either edge-latched or level-following. An edge-latched bit records a rising edge on its line and keeps the record after the line drops, until software acknowledges it. A level-following bit never records anything; it contributes to the interrupt for exactly as long as its line is high.

Software sees the controller through a small register bus inside a 4 KiB window. Each bank offers four registers: latched events, an enable mask, a write-one-to-clear acknowledge, and the raw line levels. A bank requests service when any enabled bit has a latched event or is a level-following bit whose line is high. The output is the OR of both banks, taken through one register stage.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset the event, mask and level registers of both banks are zero, `irq_out` is 0 and `bus_rdata` is 0.
- R2: Lines 0 to 31 drive bank 1, bit n; lines 32 to 63 drive bank 0, bit n-32.
- R3: The level register (bank offset 0xC) holds the value the lines had at the previous clock edge.
- R4: A rising edge on an edge-latched line sets its event bit (bank offset 0x0). The bit stays set after the line falls, and a line held high sets it only once, so acknowledging it while the line stays high leaves it clear.
- R5: A level-following bit never sets its event bit.
- R6: A write to the acknowledge register (bank offset 0x8) clears the event bits whose data bit is 1 and leaves the others as they were. Writing 1 to a level-following bit has no effect. When a rising edge and an acknowledge of the same bit arrive in the same cycle, the bit ends up set.
- R7: The mask register (bank offset 0x4) can be written and read back, and it takes part in the next output evaluation.
- R8: A bank is pending when (events OR (levels AND level_cfg)) AND mask is nonzero. `irq_out` equals the OR of both banks' pending results one clock after they change.
- R9: The bank index is (address - 0x10) >> 4 at 12-bit width, so bank 0 sits at 0x10-0x1F and bank 1 at 0x20-0x2F. Addresses outside these ranges read 0 and ignore writes. Within a bank, the only readable offsets are 0x0, 0x4 and 0xC. The acknowledge offset and any other offset read 0, and only offsets 0x4 and 0x8 take writes.
- R10: Read data appears on `bus_rdata` on the clock after the read request and holds its value until the next read.
- R11: The level configuration is 0x00000000 for bank 0 and 0x1FF00000 for bank 1, so bank 1 bits 20 to 28 follow levels and every other bit is edge-latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 64 | Interrupt request lines, synchronous to clk |
| bus_valid | input | 1 | Bus request valid for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
A line change made between edges reaches the level and event registers at the next edge. It reaches `irq_out` one edge after that. A mask or acknowledge write reaches `irq_out` on the edge after the write itself. Read data is due on the edge after the request. The bench drives all inputs on falling edges. It waits the stated number of edges before it samples `irq_out` on a falling edge. It hands every read's expected value to a scoreboard queue, and a monitor pops that value on the falling edge after the request.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NUM_BANKS    = 2;
    localparam int DEF_BANK_W   = 32;
    localparam int DEF_ADDR_W   = 12;
    localparam int WINDOW_BASE  = 16;   // first bank starts here
    localparam int STRIDE_SHIFT = 4;    // 16 bytes per bank

    localparam logic [3:0] OFS_EVENT = 4'h0;
    localparam logic [3:0] OFS_MASK  = 4'h4;
    localparam logic [3:0] OFS_ACK   = 4'h8;
    localparam logic [3:0] OFS_LEVEL = 4'hC;

    localparam logic [DEF_BANK_W-1:0] DEF_LVL_CFG_B0 = 32'h0000_0000;
    localparam logic [DEF_BANK_W-1:0] DEF_LVL_CFG_B1 = 32'h1FF0_0000;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EVENT,
        SEL_MASK,
        SEL_ACK,
        SEL_LEVEL
    } pic_sel_e;

    typedef struct packed {
        logic     hit;
        logic     bank;
        pic_sel_e sel;
    } pic_dec_t;

    function automatic pic_sel_e sel_from_offset(input logic [3:0] ofs);
        pic_sel_e s;
        case (ofs)
            OFS_EVENT: s = SEL_EVENT;
            OFS_MASK:  s = SEL_MASK;
            OFS_ACK:   s = SEL_ACK;
            OFS_LEVEL: s = SEL_LEVEL;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pic_addr_decode.sv
module pic_addr_decode
    import pic_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    output pic_dec_t             dec,
    output logic                 rd_en,
    output logic [NUM_BANKS-1:0] mask_we,
    output logic [NUM_BANKS-1:0] ack_we
);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        rel       = bus_addr - ADDR_W'(WINDOW_BASE);
        idx       = rel >> STRIDE_SHIFT;
        dec.hit   = (idx < ADDR_W'(NUM_BANKS));
        dec.bank  = idx[0];
        dec.sel   = sel_from_offset(bus_addr[3:0]);
        rd_en     = bus_valid && !bus_write;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
        always_comb begin
            mask_we[b] = bus_valid && bus_write && dec.hit &&
                         (dec.bank == b[0]) && (dec.sel == SEL_MASK);
            ack_we[b]  = bus_valid && bus_write && dec.hit &&
                         (dec.bank == b[0]) && (dec.sel == SEL_ACK);
        end
    end

endmodule

// File: rtl/pic_bank.sv
module pic_bank
    import pic_pkg::*;
#(
    parameter int              W       = DEF_BANK_W,
    parameter logic [W-1:0]    LVL_CFG = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  lines,
    input  logic          mask_we,
    input  logic          ack_we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  events,
    output logic [W-1:0]  mask,
    output logic [W-1:0]  levels,
    output logic          pending
);

    logic [W-1:0] events_q, mask_q, levels_q;
    logic [W-1:0] rise, clr, events_d;

    always_comb begin
        rise     = lines & ~levels_q & ~LVL_CFG;
        clr      = ack_we ? (wdata & ~LVL_CFG) : '0;
        events_d = (events_q & ~clr) | rise;   // new edge beats acknowledge
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            events_q <= '0;
            mask_q   <= '0;
            levels_q <= '0;
        end else begin
            events_q <= events_d;
            levels_q <= lines;
            if (mask_we) mask_q <= wdata;
        end
    end

    always_comb begin
        events  = events_q;
        mask    = mask_q;
        levels  = levels_q;
        pending = |((events_q | (levels_q & LVL_CFG)) & mask_q);
    end

    AST_LVL_NEVER_LATCH: assert property (@(posedge clk) disable iff (rst)
        (events_q & LVL_CFG) == '0) else $error("level bit latched"); // R5

    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !ack_we |=> (($past(events_q) & ~events_q) == '0)) else $error("event lost"); // R4

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (levels_q == $past(lines))) else $error("level lag"); // R3

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask_q == $past(wdata))) else $error("mask load"); // R7

endmodule

// File: rtl/pic_irq_out.sv
module pic_irq_out
    import pic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] pend,
    output logic                 irq
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |pend;
    end

    assign irq = irq_q;

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_q == $past(|pend))) else $error("irq lag"); // R8

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
    import pic_pkg::*;
#(
    parameter int                 BANK_W     = DEF_BANK_W,
    parameter int                 ADDR_W     = DEF_ADDR_W,
    parameter logic [BANK_W-1:0]  LVL_CFG_B0 = DEF_LVL_CFG_B0,
    parameter logic [BANK_W-1:0]  LVL_CFG_B1 = DEF_LVL_CFG_B1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_BANKS*BANK_W-1:0]   irq_lines,
    input  logic                          bus_valid,
    input  logic                          bus_write,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [BANK_W-1:0]             bus_wdata,
    output logic [BANK_W-1:0]             bus_rdata,
    output logic                          irq_out
);

    localparam int WIN_END = WINDOW_BASE + (NUM_BANKS << STRIDE_SHIFT);

    pic_dec_t             dec;
    logic                 rd_en;
    logic [NUM_BANKS-1:0] mask_we, ack_we, pend;
    logic [BANK_W-1:0]    ev_arr  [NUM_BANKS];
    logic [BANK_W-1:0]    msk_arr [NUM_BANKS];
    logic [BANK_W-1:0]    lvl_arr [NUM_BANKS];
    logic [BANK_W-1:0]    rd_val, rdata_q;

    pic_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .dec       (dec),
        .rd_en     (rd_en),
        .mask_we   (mask_we),
        .ack_we    (ack_we)
    );

    // Bank b takes the line group counted from the top: low lines land in the last bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] CFG = (b == 0) ? LVL_CFG_B0 : LVL_CFG_B1;
        pic_bank #(.W(BANK_W), .LVL_CFG(CFG)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .lines   (irq_lines[(NUM_BANKS-1-b)*BANK_W +: BANK_W]),
            .mask_we (mask_we[b]),
            .ack_we  (ack_we[b]),
            .wdata   (bus_wdata),
            .events  (ev_arr[b]),
            .mask    (msk_arr[b]),
            .levels  (lvl_arr[b]),
            .pending (pend[b])
        );
    end

    always_comb begin
        rd_val = '0;
        if (dec.hit) begin
            case (dec.sel)
                SEL_EVENT: rd_val = ev_arr[dec.bank];
                SEL_MASK:  rd_val = msk_arr[dec.bank];
                SEL_LEVEL: rd_val = lvl_arr[dec.bank];
                default:   rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;

    pic_irq_out u_irq (
        .clk  (clk),
        .rst  (rst),
        .pend (pend),
        .irq  (irq_out)
    );

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write &&
         ((bus_addr < ADDR_W'(WINDOW_BASE)) || (bus_addr >= ADDR_W'(WIN_END))))
        |-> (mask_we == '0 && ack_we == '0)) else $error("stray write"); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata)) else $error("rdata moved"); // R10

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_we | mask_we)) else $error("multi bank write"); // R9

endmodule

// File: tb/dual_bank_intc_tb.sv
module dual_bank_intc_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] lines = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];
    logic rd_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bank_intc u_dut (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (lines),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected value per read, on the falling edge after the request
    always @(posedge clk) rd_pend <= bus_valid && !bus_write;

    always @(negedge clk) begin
        exp_t e;
        if (rd_pend) begin
            if (sb_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10 unexpected read actual=%h expected=none", bus_rdata);
            end else begin
                e = sb_q.pop_front();
                check(e.tag, bus_rdata, e.exp);
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b0;
        bus_addr  = a;
        e.exp = exp;
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic set_line(input int idx, input logic v);
        @(negedge clk);
        lines[idx] = v;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        check(tag, {31'b0, irq_out}, {31'b0, exp});
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        chk_irq(1'b0, "R1 irq after reset");
        check("R1 rdata after reset", bus_rdata, 32'h0);
        bus_rd(12'h010, 32'h0, "R1 bank0 events");
        bus_rd(12'h014, 32'h0, "R1 bank0 mask");
        bus_rd(12'h01C, 32'h0, "R1 bank0 levels");
        bus_rd(12'h020, 32'h0, "R1 bank1 events");
        bus_rd(12'h024, 32'h0, "R1 bank1 mask");
        bus_rd(12'h02C, 32'h0, "R1 bank1 levels");

        // R2 / R3: line 3 lands in bank 1
        set_line(3, 1'b1);
        wait_cyc(1);
        bus_rd(12'h02C, 32'h8, "R2 R3 line3 bank1 level");
        bus_rd(12'h020, 32'h8, "R2 R4 line3 bank1 event");
        bus_rd(12'h01C, 32'h0, "R2 bank0 level untouched");
        chk_irq(1'b0, "R8 masked event");
        set_line(40, 1'b1);
        wait_cyc(1);
        bus_rd(12'h01C, 32'h100, "R2 line40 bank0 level");
        bus_rd(12'h010, 32'h100, "R2 line40 bank0 event");

        // R7 / R8
        bus_wr(12'h024, 32'h8);
        bus_rd(12'h024, 32'h8, "R7 mask readback");
        chk_irq(1'b1, "R8 unmasked event");

        // R4 sticky
        set_line(3, 1'b0);
        wait_cyc(2);
        chk_irq(1'b1, "R4 event held after drop");
        bus_rd(12'h020, 32'h8, "R4 event sticky");
        bus_rd(12'h02C, 32'h0, "R3 level dropped");
        bus_wr(12'h028, 32'h8);
        wait_cyc(1);
        chk_irq(1'b0, "R6 ack drops irq");
        bus_rd(12'h020, 32'h0, "R6 ack clears");

        // R4 held high sets once
        set_line(3, 1'b1);
        wait_cyc(1);
        bus_rd(12'h020, 32'h8, "R4 new edge");
        bus_wr(12'h028, 32'h8);
        wait_cyc(3);
        bus_rd(12'h020, 32'h0, "R4 held high sets once");
        chk_irq(1'b0, "R4 irq stays low while held");
        set_line(3, 1'b0);

        // R5 / R11 level bits in bank 1
        set_line(20, 1'b1);
        wait_cyc(1);
        bus_rd(12'h02C, 32'h0010_0000, "R3 level bit20");
        bus_rd(12'h020, 32'h0, "R5 level bit no event");
        chk_irq(1'b0, "R8 level masked");
        bus_wr(12'h024, 32'h0010_0000);
        wait_cyc(1);
        chk_irq(1'b1, "R8 level unmasked");
        bus_wr(12'h028, 32'hFFFF_FFFF);
        wait_cyc(1);
        chk_irq(1'b1, "R6 ack ignores level bit");
        set_line(20, 1'b0);
        wait_cyc(2);
        chk_irq(1'b0, "R8 level released");

        // R11 configuration edges
        set_line(52, 1'b1);
        set_line(52, 1'b0);
        wait_cyc(1);
        bus_rd(12'h010, 32'h0010_0100, "R11 bank0 bit20 edge");
        set_line(29, 1'b1);
        set_line(29, 1'b0);
        wait_cyc(1);
        bus_rd(12'h020, 32'h2000_0000, "R11 bank1 bit29 edge");
        set_line(28, 1'b1);
        set_line(28, 1'b0);
        wait_cyc(1);
        bus_rd(12'h020, 32'h2000_0000, "R11 bank1 bit28 level");

        // R6 partial acknowledge
        bus_wr(12'h018, 32'h100);
        bus_rd(12'h010, 32'h0010_0000, "R6 partial ack");
        bus_wr(12'h014, 32'h0010_0000);
        wait_cyc(1);
        chk_irq(1'b1, "R8 bank0 pending");
        bus_wr(12'h018, 32'h0010_0000);
        wait_cyc(1);
        chk_irq(1'b0, "R8 bank0 cleared");

        // R6 edge and acknowledge in one cycle
        @(negedge clk);
        lines[32] = 1'b1;
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = 12'h018;
        bus_wdata = 32'h1;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_rd(12'h010, 32'h1, "R6 edge beats ack");
        bus_wr(12'h018, 32'h1);
        bus_rd(12'h010, 32'h0, "R6 second ack");

        // R9 decode
        bus_wr(12'h034, 32'hFFFF_FFFF);
        bus_wr(12'h015, 32'hFFFF_FFFF);
        bus_wr(12'h004, 32'hFFFF_FFFF);
        bus_wr(12'h114, 32'hFFFF_FFFF);
        bus_rd(12'h014, 32'h0010_0000, "R9 stray writes ignored");
        bus_rd(12'h024, 32'h0010_0000, "R9 bank1 mask intact");
        bus_rd(12'h034, 32'h0, "R9 above window");
        bus_rd(12'h000, 32'h0, "R9 below window");
        bus_rd(12'h00C, 32'h0, "R9 wrapped index");
        bus_rd(12'h018, 32'h0, "R9 ack reads zero");
        bus_rd(12'h01D, 32'h0, "R9 odd offset");
        bus_rd(12'h11C, 32'h0, "R9 alias outside");

        // R10 hold
        bus_rd(12'h01C, 32'h101, "R10 level read");
        wait_cyc(3);
        check("R10 rdata holds idle", bus_rdata, 32'h101);
        bus_wr(12'h014, 32'h0010_0000);
        check("R10 rdata holds on write", bus_rdata, 32'h101);

        wait_cyc(2);
        check("R10 scoreboard drained", sb_q.size(), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule